// File: doc/BRIEF.md
# Four-Phase Fetch/Execute Sequencer

The sequencer turns a fast input clock into a repeating instruction cycle of four one-clock phases, Q1 through Q4. Exactly one phase is active in each input clock.

It runs a two-stage pipeline over that cycle. During one instruction cycle it fetches the word at the program counter from a 512 x 12 program memory. During the next cycle it holds that word in the instruction register for a downstream core to execute. While one instruction executes, the next one is fetched, so each instruction takes one instruction cycle of four input clocks.

The block also produces a clock-out at one quarter of the input rate, an execute strobe and the phase code. It accepts two inputs from the core:

- a branch load with a target address, which replaces the next program counter increment;
- a flush, which discards the prefetched word after a taken branch.

Top module: `quad_phase_seq`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) leaves the phase at Q1, `imem_addr` at 0, `ir` at the NOP word 12'h000, `clkout` low and `imem_ren` low.
- R2: `phase` steps through 0,1,2,3 (Q1,Q2,Q3,Q4) and then back to 0, one step per clock. `phase_oh` bit i is high exactly when `phase` equals i, so exactly one bit is ever set.
- R3: `clkout` is low while the phase is Q1 or Q2 and high while it is Q3 or Q4.
- R4: `imem_addr` holds the program counter. It changes only on the clock edge that enters Q1 and stays stable for the whole cycle. Without a branch it rises by 1 per instruction cycle, wrapping from 511 to 0.
- R5: `imem_ren` is high during Q2, Q3 and Q4 and low during Q1.
- R6: The value of `imem_rdata` at the Q4 edge is loaded into `ir` on entering Q1. `ir` then stays constant for the four phases of that execute cycle, so execution trails the fetch by one instruction cycle.
- R7: When `flush` is high at the Q4 edge, `ir` receives 12'h000 instead of `imem_rdata`. `flush` in other phases has no effect on `ir`.
- R8: When `br_load` is high at the Q4 edge, the next program counter is `br_target` instead of the increment. `br_load` in other phases has no effect on the program counter.
- R9: `exec_stb` is high during Q1 only, marking the first clock of each newly loaded instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input oscillator clock |
| rst | input | 1 | Synchronous reset, active high |
| imem_rdata | input | 12 | Program memory read data (combinational on address) |
| flush | input | 1 | Replace the word latched at Q4 with a NOP |
| br_load | input | 1 | Load `br_target` as the next program counter at Q4 |
| br_target | input | 9 | Branch target address |
| imem_addr | output | 9 | Program memory address (the program counter) |
| imem_ren | output | 1 | Program memory read enable, Q2 to Q4 |
| ir | output | 12 | Instruction register, the word being executed |
| exec_stb | output | 1 | High during Q1 of each execute cycle |
| phase | output | 2 | Current phase code, 0 = Q1 to 3 = Q4 |
| phase_oh | output | 4 | One-hot phase, bit i for phase code i |
| clkout | output | 1 | Input clock divided by four |

## Verification
The hardest situations to reach are a flush or branch load that lands exactly on the Q4 edge, the same input raised in another phase where it must be ignored, and a branch aimed at the top address so that the following increment wraps.

Random stimulus raises `flush` and `br_load` in every phase with a fixed seed. A bench model that updates only at Q4 separates the accepted requests from the ignored ones.

Directed sequences add a branch to 511 followed by a free-running wrap to 0, a flush combined with a branch in the same Q4, and a reset asserted in the middle of a cycle.

// File: rtl/qseq_pkg.sv
package qseq_pkg;
    localparam int unsigned NUM_PHASES = 4;
    localparam int unsigned DEF_PC_W   = 9;
    localparam int unsigned DEF_IW     = 12;

    typedef enum logic [1:0] {
        PH_Q1 = 2'd0,
        PH_Q2 = 2'd1,
        PH_Q3 = 2'd2,
        PH_Q4 = 2'd3
    } phase_e;
endpackage

// File: rtl/qseq_phase.sv
module qseq_phase
    import qseq_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    output logic [1:0]            phase,
    output logic [NUM_PHASES-1:0] phase_oh,
    output logic                  clkout
);
    typedef struct packed {
        phase_e ph;
        logic   ck;
    } ph_state_t;

    ph_state_t  s_d, s_q;
    logic [1:0] ph_inc;

    always_comb begin
        s_d    = s_q;
        ph_inc = s_q.ph + 2'd1;
        s_d.ph = phase_e'(ph_inc);
        // high for the second half of the instruction cycle
        s_d.ck = (s_d.ph == PH_Q3) || (s_d.ph == PH_Q4);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s_q.ph <= PH_Q1;
            s_q.ck <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    for (genvar i = 0; i < NUM_PHASES; i++) begin : g_oh
        assign phase_oh[i] = (s_q.ph == phase_e'(i));
    end

    assign phase  = s_q.ph;
    assign clkout = s_q.ck;
endmodule

// File: rtl/qseq_pc.sv
module qseq_pc #(
    parameter int unsigned PC_W = 9
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            adv,
    input  logic            br_load,
    input  logic [PC_W-1:0] br_target,
    output logic [PC_W-1:0] pc
);
    typedef struct packed {
        logic [PC_W-1:0] pc;
    } pc_state_t;

    pc_state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (adv) begin
            // natural wrap at the top of the address space
            s_d.pc = br_load ? br_target : s_q.pc + PC_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) s_q.pc <= '0;
        else     s_q    <= s_d;
    end

    assign pc = s_q.pc;
endmodule

// File: rtl/qseq_ir.sv
module qseq_ir #(
    parameter int unsigned    IW  = 12,
    parameter logic [IW-1:0]  NOP = '0
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          latch,
    input  logic          flush,
    input  logic [IW-1:0] rdata,
    output logic [IW-1:0] ir
);
    typedef struct packed {
        logic [IW-1:0] word;
    } ir_state_t;

    ir_state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (latch) s_d.word = flush ? NOP : rdata;
    end

    always_ff @(posedge clk) begin
        if (rst) s_q.word <= NOP;
        else     s_q      <= s_d;
    end

    assign ir = s_q.word;
endmodule

// File: rtl/quad_phase_seq.sv
module quad_phase_seq
    import qseq_pkg::*;
#(
    parameter int unsigned   PC_W = DEF_PC_W,
    parameter int unsigned   IW   = DEF_IW,
    parameter logic [IW-1:0] NOP  = '0
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [IW-1:0]         imem_rdata,
    input  logic                  flush,
    input  logic                  br_load,
    input  logic [PC_W-1:0]       br_target,
    output logic [PC_W-1:0]       imem_addr,
    output logic                  imem_ren,
    output logic [IW-1:0]         ir,
    output logic                  exec_stb,
    output logic [1:0]            phase,
    output logic [NUM_PHASES-1:0] phase_oh,
    output logic                  clkout
);
    logic q4_now;

    qseq_phase u_phase (
        .clk      (clk),
        .rst      (rst),
        .phase    (phase),
        .phase_oh (phase_oh),
        .clkout   (clkout)
    );

    assign q4_now = phase_oh[PH_Q4];

    qseq_pc #(.PC_W(PC_W)) u_pc (
        .clk       (clk),
        .rst       (rst),
        .adv       (q4_now),
        .br_load   (br_load),
        .br_target (br_target),
        .pc        (imem_addr)
    );

    qseq_ir #(.IW(IW), .NOP(NOP)) u_ir (
        .clk   (clk),
        .rst   (rst),
        .latch (q4_now),
        .flush (flush),
        .rdata (imem_rdata),
        .ir    (ir)
    );

    assign imem_ren = ~phase_oh[PH_Q1];
    assign exec_stb = phase_oh[PH_Q1];
endmodule

// File: rtl/qseq_chk.sv
module qseq_chk #(
    parameter int unsigned   PC_W = 9,
    parameter int unsigned   IW   = 12,
    parameter logic [IW-1:0] NOP  = '0
) (
    input logic            clk,
    input logic            rst,
    input logic            flush,
    input logic            br_load,
    input logic [PC_W-1:0] br_target,
    input logic [PC_W-1:0] imem_addr,
    input logic            imem_ren,
    input logic [IW-1:0]   ir,
    input logic [1:0]      phase,
    input logic [3:0]      phase_oh,
    input logic            clkout
);
    AST_PHASE_STEP: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> phase == 2'($past(phase) + 2'd1)); // R2
    AST_ONE_PHASE: assert property (@(posedge clk) disable iff (rst)
        $countones(phase_oh) == 1); // R2
    AST_CLKOUT_HALF: assert property (@(posedge clk) disable iff (rst)
        clkout == phase[1]); // R3
    AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (rst)
        (phase != 2'd0) |-> $stable(imem_addr)); // R4
    AST_PC_STEP: assert property (@(posedge clk) disable iff (rst)
        (phase == 2'd3 && !br_load) |=> imem_addr == PC_W'($past(imem_addr) + 1'b1)); // R4
    AST_REN_START: assert property (@(posedge clk) disable iff (rst)
        (phase == 2'd1) |-> (imem_ren && !$past(imem_ren))); // R5
    AST_IR_HOLD: assert property (@(posedge clk) disable iff (rst)
        (phase != 2'd0) |-> $stable(ir)); // R6
    AST_FLUSH_NOP: assert property (@(posedge clk) disable iff (rst)
        (phase == 2'd3 && flush) |=> ir == NOP); // R7
    AST_BRANCH_LOAD: assert property (@(posedge clk) disable iff (rst)
        (phase == 2'd3 && br_load) |=> imem_addr == $past(br_target)); // R8
endmodule

bind quad_phase_seq qseq_chk #(.PC_W(PC_W), .IW(IW), .NOP(NOP)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .flush     (flush),
    .br_load   (br_load),
    .br_target (br_target),
    .imem_addr (imem_addr),
    .imem_ren  (imem_ren),
    .ir        (ir),
    .phase     (phase),
    .phase_oh  (phase_oh),
    .clkout    (clkout)
);

// File: tb/sim_quad_phase_seq.sv
module sim_quad_phase_seq;
    localparam int PC_W = 9;
    localparam int IW   = 12;
    localparam logic [IW-1:0] NOP = 12'h000;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [IW-1:0]   imem_rdata;
    logic            flush = 1'b0;
    logic            br_load = 1'b0;
    logic [PC_W-1:0] br_target = '0;
    logic [PC_W-1:0] imem_addr;
    logic            imem_ren;
    logic [IW-1:0]   ir;
    logic            exec_stb;
    logic [1:0]      phase;
    logic [3:0]      phase_oh;
    logic            clkout;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    // model state
    int unsigned     m_ph = 0;
    logic [PC_W-1:0] m_pc = '0;
    logic [IW-1:0]   m_ir = NOP;

    always #2 clk = ~clk;

    function automatic logic [IW-1:0] mem_word(input logic [PC_W-1:0] a);
        logic [IW-1:0] w;
        w = IW'(a * 157 + 13) ^ IW'({a, 3'b000});
        return w | 12'h001;
    endfunction

    assign imem_rdata = mem_word(imem_addr);

    quad_phase_seq u0 (
        .clk(clk), .rst(rst), .imem_rdata(imem_rdata), .flush(flush),
        .br_load(br_load), .br_target(br_target), .imem_addr(imem_addr),
        .imem_ren(imem_ren), .ir(ir), .exec_stb(exec_stb), .phase(phase),
        .phase_oh(phase_oh), .clkout(clkout)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic check_all();
        chk("R2", "phase", int'(phase), int'(m_ph));
        chk("R2", "phase_oh", int'(phase_oh), 1 << m_ph);
        chk("R3", "clkout", int'(clkout), (m_ph >= 2) ? 1 : 0);
        chk("R4", "imem_addr", int'(imem_addr), int'(m_pc));
        chk("R5", "imem_ren", int'(imem_ren), (m_ph != 0) ? 1 : 0);
        chk("R6", "ir", int'(ir), int'(m_ir));
        chk("R9", "exec_stb", int'(exec_stb), (m_ph == 0) ? 1 : 0);
    endtask

    // update model for the coming edge, using inputs now applied
    task automatic model_step();
        if (rst) begin
            m_ph = 0; m_pc = '0; m_ir = NOP;
        end else begin
            if (m_ph == 3) begin
                m_ir = flush ? NOP : mem_word(m_pc);
                m_pc = br_load ? br_target : PC_W'(m_pc + 1'b1);
            end
            m_ph = (m_ph + 1) % 4;
        end
    endtask

    task automatic cyc(input bit r, input bit f, input bit b, input logic [PC_W-1:0] t);
        rst = r; flush = f; br_load = b; br_target = t;
        model_step();
        @(negedge clk);
        check_all();
    endtask

    initial begin
        int unsigned seed;
        seed = 32'd12345;
        void'($urandom(seed));
        @(negedge clk);
        cyc(1'b1, 1'b0, 1'b0, '0);
        // R1 reset state
        chk("R1", "reset phase", int'(phase), 0);
        chk("R1", "reset addr", int'(imem_addr), 0);
        chk("R1", "reset ir", int'(ir), int'(NOP));
        chk("R1", "reset clkout", int'(clkout), 0);
        chk("R1", "reset ren", int'(imem_ren), 0);
        // plain sequential run
        for (int i = 0; i < 40; i++) cyc(1'b0, 1'b0, 1'b0, '0);
        // R8 branch to top, then wrap (R4)
        while (m_ph != 3) cyc(1'b0, 1'b0, 1'b0, '0);
        cyc(1'b0, 1'b0, 1'b1, 9'd511);
        for (int i = 0; i < 4; i++) cyc(1'b0, 1'b0, 1'b0, '0);
        chk("R4", "wrap addr", int'(imem_addr), 0);
        // R7 flush together with branch
        while (m_ph != 3) cyc(1'b0, 1'b0, 1'b0, '0);
        cyc(1'b0, 1'b1, 1'b1, 9'd100);
        chk("R7", "flush ir", int'(ir), int'(NOP));
        chk("R8", "branch addr", int'(imem_addr), 100);
        // R7/R8 ignored outside Q4
        for (int i = 0; i < 3; i++) cyc(1'b0, 1'b1, 1'b1, 9'd7);
        cyc(1'b0, 1'b0, 1'b0, '0);
        chk("R8", "ignored branch", int'(imem_addr), 101);
        chk("R7", "ignored flush", int'(ir), int'(mem_word(9'd100)));
        // random mix
        for (int i = 0; i < 4000; i++) begin
            cyc(($urandom % 300) == 0, ($urandom % 4) == 0,
                ($urandom % 4) == 0, PC_W'($urandom));
        end
        // mid-cycle reset, R1
        cyc(1'b0, 1'b0, 1'b0, '0);
        cyc(1'b1, 1'b0, 1'b0, '0);
        chk("R1", "mid reset addr", int'(imem_addr), 0);
        chk("R1", "mid reset phase", int'(phase), 0);
        for (int i = 0; i < 2200; i++) cyc(1'b0, 1'b0, 1'b0, '0);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 150000; i++) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule